// File: doc/BRIEF.md
# ADC Conversion Clock and Start Controller

This block is the control front end of a successive-approximation converter. It owns one 8-bit configuration register, written and read over a small single-cycle bus port. From that register it works out three things: which clock paces the conversion, how far that clock is divided, and how a conversion is started. The analog array, the bit-by-bit approximation sequence and the result storage are all outside this block.

The paced clock is either the bus clock itself or an asynchronous alternate clock. The alternate clock is synchronized and its rising edges become one-cycle ticks. A force bit can override the selection and pin the source to the bus clock. A counter then divides the chosen ticks by 1, 2, 4 or 8 and emits a one-cycle conversion-clock enable. The mode field sets the result width (8 or 10 bits, both right-justified downstream) and the start source. A conversion can start on a write to the status address or on a rising edge of the synchronized external trigger. One mode code is reserved. It is stored, but it never starts a conversion.

Top module: `adc_ckctl`

## Requirements
- R1: While reset is held and right after it is released, the register reads 0x00, and `wide10`, `lowPower`, `startPulse` and `convClkEn` are all 0. With the alternate clock idle, no enable appears.
- R2: A write at address 0 stores all 8 bits, including the reserved mode code. Address 0 reads back the stored value combinationally, and address 1 reads 0x00.
- R3: Register bits [6:5] set the divide ratio N: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. With the bus clock as source, the cycle after the write edge is count 0, and `convClkEn` is high in exactly those cycles i where i mod N equals N-1.
- R4: Bit 0 set forces the bus-clock source. With bit 0 clear, bit 4 = 1 selects the bus clock and bit 4 = 0 selects the alternate clock. On the alternate clock, each N rising edges produce one enable, and an idle alternate clock produces none.
- R5: A write that changes the divide field or the effective source restarts the count at 0. A write that changes neither keeps the count running.
- R6: `wide10` is 1 when bits [3:2] are 01 or 11, and 0 when they are 00 or 10.
- R7: In modes 00 and 01, a write to address 1 makes `startPulse` high for exactly the one cycle after the write edge. In these modes the trigger input has no effect.
- R8: In mode 11, a rising trigger edge makes one single-cycle `startPulse` in the third cycle after it is applied (two synchronizer stages plus the start register). Writes to address 1 produce no pulse.
- R9: In mode 10 (reserved), neither a trigger edge nor a write to address 1 produces a pulse.
- R10: `lowPower` follows bit 7. Bit 1 (long sample) is only stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, one cycle per access |
| busAddr | input | 1 | 0 = configuration register, 1 = status (start) address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed location |
| altClk | input | 1 | Asynchronous alternate clock |
| extTrig | input | 1 | Asynchronous external start trigger |
| convClkEn | output | 1 | One-cycle conversion clock enable |
| startPulse | output | 1 | One-cycle conversion start |
| wide10 | output | 1 | 1 = 10-bit result, 0 = 8-bit |
| lowPower | output | 1 | Reduced-power configuration flag |

## Verification
The assertions assume that two writes to the status address never arrive on consecutive cycles. They also assume that the mode does not change while a trigger edge is still inside the synchronizer. The stimulus always leaves at least one idle cycle after each status write, and it waits several cycles after every trigger change before it rewrites the mode. The alternate clock and the trigger are driven with high and low phases of several bus cycles, so every edge survives synchronization. The stimulus holds the alternate clock low whenever the source is switched.

// File: rtl/adc_ckctl_pkg.sv
package adc_ckctl_pkg;

  localparam int REG_W    = 8;
  localparam int DIV_W    = 2;
  localparam int CNT_W    = (1 << DIV_W) - 1;

  // register bit positions
  localparam int B_LOWPWR = 7;
  localparam int B_DIVHI  = 6;
  localparam int B_DIVLO  = 5;
  localparam int B_SRCBUS = 4;
  localparam int B_MODEHI = 3;
  localparam int B_MODELO = 2;
  localparam int B_LSMP   = 1;
  localparam int B_FORCE  = 0;

  typedef enum logic [1:0] {
    MODE_W8_WR  = 2'b00,
    MODE_W10_WR = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_W10_EX = 2'b11
  } convMode_t;

  typedef struct packed {
    logic srcTick;
    logic divRestart;
    logic wrStart;
    logic trigStart;
  } ctrlStrobe_t;

  function automatic logic busSource(input logic [REG_W-1:0] r);
    return r[B_FORCE] | r[B_SRCBUS];
  endfunction

endpackage

// File: rtl/adc_ckctl_sync.sv
module adc_ckctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut,
  output logic riseOut
);
  logic [STAGES-1:0] chainQ;
  logic              lastQ;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chainQ <= '0;
        else       chainQ <= asyncIn;
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chainQ <= '0;
        else       chainQ <= {chainQ[STAGES-2:0], asyncIn};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= chainQ[STAGES-1];

  assign syncOut = chainQ[STAGES-1];
  assign riseOut = chainQ[STAGES-1] & ~lastQ;
endmodule

// File: rtl/adc_ckctl_ctrl.sv
module adc_ckctl_ctrl
  import adc_ckctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic             busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic             altClk,
  input  logic             extTrig,
  output logic [REG_W-1:0] cfgQ,
  output ctrlStrobe_t      strobes
);
  logic      cfgWr;
  logic      statusWr;
  logic      altRise;
  logic      trigRise;
  logic      altLevel;
  logic      trigLevel;
  logic      srcNow;
  logic      srcNext;
  convMode_t modeNow;

  assign cfgWr    = busWe & ~busAddr;
  assign statusWr = busWe &  busAddr;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)      cfgQ <= '0;
    else if (cfgWr) cfgQ <= busWdata;

  assign busRdata = busAddr ? '0 : cfgQ;

  adc_ckctl_sync #(.STAGES(SYNC_STAGES)) altSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(altClk),
    .syncOut(altLevel), .riseOut(altRise)
  );

  adc_ckctl_sync #(.STAGES(SYNC_STAGES)) trigSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(extTrig),
    .syncOut(trigLevel), .riseOut(trigRise)
  );

  assign srcNow  = busSource(cfgQ);
  assign srcNext = busSource(busWdata);
  assign modeNow = convMode_t'(cfgQ[B_MODEHI:B_MODELO]);

  always_comb begin
    strobes            = '0;
    strobes.srcTick    = srcNow ? 1'b1 : altRise;
    strobes.divRestart = cfgWr &&
                         ((busWdata[B_DIVHI:B_DIVLO] != cfgQ[B_DIVHI:B_DIVLO]) ||
                          (srcNext != srcNow));
    strobes.wrStart    = statusWr &&
                         ((modeNow == MODE_W8_WR) || (modeNow == MODE_W10_WR));
    strobes.trigStart  = trigRise && (modeNow == MODE_W10_EX);
  end

  logic unusedLevels;
  assign unusedLevels = altLevel ^ trigLevel;
endmodule

// File: rtl/adc_ckctl_dp.sv
module adc_ckctl_dp
  import adc_ckctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  input  logic [1:0]       modeSel,
  input  logic             lowPwrBit,
  input  ctrlStrobe_t      strobes,
  output logic             convClkEn,
  output logic             startPulse,
  output logic             wide10,
  output logic             lowPower
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] limit;
  logic             atLimit;
  logic             startQ;

  // thermometer limit: N-1 for N = 2**divSel
  always_comb begin
    limit = '0;
    for (int k = 0; k < CNT_W; k++)
      if (k < int'(divSel)) limit[k] = 1'b1;
  end

  assign atLimit = (cntQ == limit);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                   cntQ <= '0;
    else if (strobes.divRestart) cntQ <= '0;
    else if (strobes.srcTick)    cntQ <= atLimit ? '0 : cntQ + 1'b1;

  assign convClkEn = strobes.srcTick & atLimit;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) startQ <= 1'b0;
    else       startQ <= strobes.wrStart | strobes.trigStart;

  assign startPulse = startQ;

  always_comb begin
    unique case (convMode_t'(modeSel))
      MODE_W10_WR, MODE_W10_EX: wide10 = 1'b1;
      default:                  wide10 = 1'b0;
    endcase
  end

  assign lowPower = lowPwrBit;
endmodule

// File: rtl/adc_ckctl.sv
module adc_ckctl
  import adc_ckctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic       busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       altClk,
  input  logic       extTrig,
  output logic       convClkEn,
  output logic       startPulse,
  output logic       wide10,
  output logic       lowPower
);
  logic [REG_W-1:0] cfgQ;
  ctrlStrobe_t      strobes;
  logic             trigStartTap;

  adc_ckctl_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .altClk(altClk), .extTrig(extTrig),
    .cfgQ(cfgQ), .strobes(strobes)
  );

  adc_ckctl_dp dp_i (
    .clk(clk), .rstN(rstN),
    .divSel(cfgQ[B_DIVHI:B_DIVLO]),
    .modeSel(cfgQ[B_MODEHI:B_MODELO]),
    .lowPwrBit(cfgQ[B_LOWPWR]),
    .strobes(strobes),
    .convClkEn(convClkEn), .startPulse(startPulse),
    .wide10(wide10), .lowPower(lowPower)
  );

  assign trigStartTap = strobes.trigStart;
endmodule

// File: rtl/adc_ckctl_chk.sv
module adc_ckctl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busWe,
  input logic       busAddr,
  input logic [7:0] cfgQ,
  input logic       trigStart,
  input logic       convClkEn,
  input logic       startPulse
);
  logic onBus;
  logic cfgWrite;
  assign onBus    = cfgQ[0] | cfgQ[4];
  assign cfgWrite = busWe & ~busAddr;

  // R1: reset clears the register
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> (cfgQ == 8'h00));

  // R3: divide by 1 on the bus clock gives an enable every cycle
  p_div1_bus_r3: assert property (@(posedge clk) disable iff (!rstN)
    (onBus && cfgQ[6:5] == 2'b00) |-> convClkEn);

  // R3: ratios above 1 never give back-to-back enables
  p_div_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (convClkEn && cfgQ[6:5] != 2'b00 && !cfgWrite) |=> !convClkEn);

  // R7: a start lasts one cycle
  p_start_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R8: external mode ignores status writes
  p_ext_no_wrstart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[3:2] == 2'b11 && $past(cfgQ[3:2]) == 2'b11 && !$past(trigStart)) |-> !startPulse);

  // R9: reserved mode never starts
  p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[3:2] == 2'b10 && $past(cfgQ[3:2]) == 2'b10) |-> !startPulse);
endmodule

bind adc_ckctl adc_ckctl_chk chk_i (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
  .cfgQ(cfgQ), .trigStart(trigStartTap),
  .convClkEn(convClkEn), .startPulse(startPulse)
);

// File: tb/adc_ckctl_tb_top.sv
module adc_ckctl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       altClk = 1'b0;
  logic       extTrig = 1'b0;
  logic       convClkEn, startPulse, wide10, lowPower;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  adc_ckctl dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .altClk(altClk), .extTrig(extTrig),
    .convClkEn(convClkEn), .startPulse(startPulse), .wide10(wide10), .lowPower(lowPower)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic busWrite(input logic a, input logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busAddr = 1'b0;
  endtask

  task automatic countStarts(input int cycles, output int n, output int firstAt);
    n = 0; firstAt = -1;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (startPulse) begin
        n++;
        if (firstAt < 0) firstAt = i;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n, firstAt, bad, nDiv, enCnt;
    repeat (3) @(negedge clk);
    check(busRdata == 8'h00 && !convClkEn && !startPulse, "R1 in reset", busRdata, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(busRdata == 8'h00, "R1 register after reset", busRdata, 0);
    check(!wide10 && !lowPower && !startPulse && !convClkEn, "R1 outputs after reset",
          {wide10, lowPower, startPulse, convClkEn}, 0);

    // R2 / R6 / R10: exhaustive write-readback and decode
    begin
      int badRd = 0, badW = 0, badLp = 0, badSt = 0;
      for (int v = 0; v < 256; v++) begin
        busWrite(1'b0, v[7:0]);
        if (busRdata != v[7:0]) badRd++;
        if (wide10 != v[2]) badW++;
        if (lowPower != v[7]) badLp++;
        busAddr = 1'b1; #1;
        if (busRdata != 8'h00) badSt++;
        busAddr = 1'b0;
      end
      check(badRd == 0, "R2 readback all codes", badRd, 0);
      check(badSt == 0, "R2 status address reads zero", badSt, 0);
      check(badW == 0, "R6 width decode all codes", badW, 0);
      check(badLp == 0, "R10 low-power flag all codes", badLp, 0);
    end

    // R3 / R4 / R5: bus-clock divide sweep, selected by bit 4 or forced by bit 0
    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 4; d++) begin
        nDiv = 1 << d;
        busWrite(1'b0, 8'((d << 5) | (s ? 8'h01 : 8'h10)));
        bad = 0;
        for (int i = 0; i < 32; i++) begin
          if (convClkEn != ((i % nDiv) == nDiv - 1)) bad++;
          @(negedge clk);
        end
        check(bad == 0, s ? "R4 forced bus source R3 ratio R5 restart" :
                            "R3 ratio on bus clock R5 restart", bad, 0);
      end
    end

    // R4: alternate clock idle gives nothing
    busWrite(1'b0, 8'h20);
    enCnt = 0;
    for (int i = 0; i < 32; i++) begin
      if (convClkEn) enCnt++;
      @(negedge clk);
    end
    check(enCnt == 0, "R4 idle alternate clock", enCnt, 0);

    // R4: alternate clock division
    for (int d = 0; d < 4; d++) begin
      nDiv = 1 << d;
      busWrite(1'b0, 8'(d << 5));
      enCnt = 0;
      for (int e = 0; e < 16; e++) begin
        altClk = 1'b1;
        repeat (4) begin @(negedge clk); if (convClkEn) enCnt++; end
        altClk = 1'b0;
        repeat (4) begin @(negedge clk); if (convClkEn) enCnt++; end
      end
      repeat (6) begin @(negedge clk); if (convClkEn) enCnt++; end
      check(enCnt == 16 / nDiv, "R4 alternate clock ratio", enCnt, 16 / nDiv);
    end

    // R5: write that leaves divider and source alone keeps counting
    busWrite(1'b0, 8'h50);
    @(negedge clk);
    busWrite(1'b0, 8'hD0);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      if (convClkEn != (((i + 2) % 4) == 3)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R5 no restart on unrelated write", bad, 0);
    check(lowPower == 1'b1, "R10 low-power set", lowPower, 1);

    // R10: long-sample bit stored
    busWrite(1'b0, 8'h12);
    check(busRdata == 8'h12 && !lowPower, "R10 long-sample readback", busRdata, 8'h12);

    // R7: write-started modes
    for (int m = 0; m < 2; m++) begin
      busWrite(1'b0, 8'(8'h10 | (m << 2)));
      @(negedge clk);
      busWrite(1'b1, 8'hA5);
      check(startPulse == 1'b1, "R7 start after status write", startPulse, 1);
      @(negedge clk);
      check(startPulse == 1'b0, "R7 start one cycle", startPulse, 0);
      extTrig = 1'b1;
      countStarts(8, n, firstAt);
      extTrig = 1'b0;
      repeat (4) @(negedge clk);
      check(n == 0, "R7 trigger ignored", n, 0);
    end

    // R8: external mode
    busWrite(1'b0, 8'h1C);
    repeat (2) @(negedge clk);
    extTrig = 1'b1;
    countStarts(10, n, firstAt);
    check(n == 1, "R8 one start per trigger edge", n, 1);
    check(firstAt == 3, "R8 trigger latency", firstAt, 3);
    extTrig = 1'b0;
    repeat (4) @(negedge clk);
    busWrite(1'b1, 8'hFF);
    check(startPulse == 1'b0, "R8 status write ignored", startPulse, 0);
    countStarts(6, n, firstAt);
    check(n == 0, "R8 status write ignored later", n, 0);

    // R9: reserved mode
    busWrite(1'b0, 8'h18);
    check(busRdata == 8'h18 && !wide10, "R9 reserved code stored", busRdata, 8'h18);
    @(negedge clk);
    busWrite(1'b1, 8'h01);
    n = startPulse ? 1 : 0;
    extTrig = 1'b1;
    countStarts(8, bad, firstAt);
    extTrig = 1'b0;
    repeat (4) @(negedge clk);
    check(n + bad == 0, "R9 no start in reserved mode", n + bad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule